// File: doc/BRIEF.md
# Single-Cycle Load/Store Core

A 32-bit core that completes one instruction per clock. Each cycle it fetches a word from its internal instruction store, decodes it, reads two registers, runs the main ALU and the data store, and writes the result back. Branch targets come from a dedicated adder. The main ALU only provides the equality test. Supported operations are register add, subtract, and, or and signed set-less-than, immediate add, load and store with base plus offset, branch-if-equal, and a register-indexed load that adds two registers to form the address.

Both stores are internal word arrays. They are filled through a load port, normally while the core is held in reset. The write-back selector has no control line of its own. The memory-read enable drives it. For the observation of execution, the core exposes its PC, the register write it commits this cycle, and the store it commits this cycle.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and dm_we_o is 0. Asserting rst_ni clears the PC at once, without waiting for a clock edge, and clears all registers.
- R2: R-format (opcode 000000; rs in bits 25:21, rt in bits 20:16, rd in bits 15:11, funct in bits 5:0) writes rd. The funct codes are 100000 add, 100010 subtract rs−rt, 100100 and, 100101 or, and 101010 set-less-than. Set-less-than gives 1 when rs < rt as signed numbers, and 0 otherwise.
- R3: Immediate add (opcode 001000; immediate in bits 15:0) writes rt with rs plus the sign-extended immediate.
- R4: Load (opcode 100011) writes rt with the data word at byte address rs + sign-extended immediate. The word index is bits 7:2 of that address.
- R5: Store (opcode 101011) writes rt data to byte address rs + sign-extended immediate. It writes no register. A later load sees the stored value.
- R6: Branch-if-equal (opcode 000100) sets the next PC to PC+4 + (sign-extended immediate << 2) when rs equals rt. Otherwise the next PC is PC+4. Every other instruction advances the PC by 4.
- R7: Register-indexed load (opcode 110000, R-format fields) writes rd with the data word at byte address rs + rt.
- R8: Register 0 always reads as 0. A write aimed at it is still shown on the write outputs, but it leaves nothing behind.
- R9: Any other opcode writes no register, stores nothing and does not branch. The PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_we_i | input | 1 | Write one word into a store through the load port |
| load_dmem_i | input | 1 | Load target: 0 selects the instruction store, 1 selects the data store |
| load_addr_i | input | LOAD_AW | Word index for the load port |
| load_data_i | input | 32 | Word written by the load port |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | The instruction writes a register |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | The instruction stores to the data store |
| dm_addr_o | output | 32 | Byte address of the data access |
| dm_wdata_o | output | 32 | Store data |

## Verification
One program exercises every operation class in turn. Operands are chosen so that each one separates a pair of similar behaviours. A negative immediate and a negative difference expose any missing sign extension. Set-less-than is run in both operand orders to separate the signed compare from the unsigned compare. The two loads hit different words, which separates the base-plus-offset address from the base-plus-register address. A store followed by a load of the same word shows the store landed. A taken forward branch, an untaken branch and a taken backward branch tell the target adder apart from PC+4. A write to register 0, followed by a read of it, and an unknown opcode confirm that nothing is left behind. Directed steps then apply reset before the run and assert it asynchronously in the middle of the run.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;
  localparam int unsigned RAW  = $clog2(NREG);

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_ADDI  = 6'b001000;
  localparam logic [5:0] OPC_LW    = 6'b100011;
  localparam logic [5:0] OPC_SW    = 6'b101011;
  localparam logic [5:0] OPC_LDX   = 6'b110000;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aop_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic reg_dst;
    logic alu_src;
    logic reg_write;
    logic mem_read;   // also selects memory data for write-back
    logic mem_write;
    logic branch;
    aop_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o,
  output logic       known_o
);

  always_comb begin
    ctrl_o  = '{reg_dst: 1'b0, alu_src: 1'b0, reg_write: 1'b0, mem_read: 1'b0,
                mem_write: 1'b0, branch: 1'b0, alu_op: AOP_ADD};
    known_o = 1'b1;
    case (opcode_i)
      OPC_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = AOP_FUNCT;
      end
      OPC_ADDI: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.reg_write = 1'b1;
      end
      OPC_LW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.mem_read  = 1'b1;
      end
      OPC_LDX: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.mem_read  = 1'b1;
      end
      OPC_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = AOP_SUB;
      end
      default: known_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  aop_e       alu_op_i,
  input  logic [5:0] funct_i,
  output alu_fn_e    fn_o
);

  always_comb begin
    fn_o = ALU_ADD;
    case (alu_op_i)
      AOP_SUB:   fn_o = ALU_SUB;
      AOP_FUNCT: begin
        case (funct_i)
          FN_SUB:  fn_o = ALU_SUB;
          FN_AND:  fn_o = ALU_AND;
          FN_OR:   fn_o = ALU_OR;
          FN_SLT:  fn_o = ALU_SLT;
          default: fn_o = ALU_ADD;
        endcase
      end
      default:   fn_o = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);

  logic [W-1:0] diff;
  logic         lt_s;

  assign diff = a_i - b_i;
  // signed less-than from the subtraction and operand signs
  assign lt_s = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : diff[W-1];

  always_comb begin
    case (fn_i)
      ALU_SUB: y_o = diff;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, lt_s};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned NR = NREG,
  localparam int unsigned AW = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o
);

  logic [W-1:0] regs [NR];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         q <= '0;
        else if (we_i && wa_i == AW'(g))     q <= wd_i;
      end
      assign regs[g] = q;
    end
  end

  assign rd1_o = regs[ra1_i];
  assign rd2_o = regs[ra2_i];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> regs[$past(wa_i)] == $past(wd_i));

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64,
  parameter int unsigned LOAD_AW    = 8,
  localparam int unsigned IAW = $clog2(IMEM_WORDS),
  localparam int unsigned DAW = $clog2(DMEM_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_we_i,
  input  logic               load_dmem_i,
  input  logic [LOAD_AW-1:0] load_addr_i,
  input  logic [XLEN-1:0]    load_data_i,
  output logic [XLEN-1:0]    pc_o,
  output logic               rf_we_o,
  output logic [RAW-1:0]     rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic               dm_we_o,
  output logic [XLEN-1:0]    dm_addr_o,
  output logic [XLEN-1:0]    dm_wdata_o
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target;
  logic [XLEN-1:0] instr, imm_sx;
  logic [5:0]      opcode, funct;
  logic [RAW-1:0]  rs, rt, rd, dst;
  logic [XLEN-1:0] rs_data, rt_data, alu_b, alu_y, dm_rdata, wb_data;
  logic            alu_zero, taken, op_known, dm_we;
  logic [DAW-1:0]  dm_idx;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;

  // fetch and load port
  always_ff @(posedge clk_i) begin
    if (load_we_i && !load_dmem_i) imem[load_addr_i[IAW-1:0]] <= load_data_i;
  end

  assign instr  = imem[pc_q[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_ctrl i_ctrl (
    .opcode_i (opcode),
    .ctrl_o   (ctrl),
    .known_o  (op_known)
  );

  sc_alu_ctrl i_alu_ctrl (
    .alu_op_i (ctrl.alu_op),
    .funct_i  (funct),
    .fn_o     (alu_fn)
  );

  assign dst = ctrl.reg_dst ? rd : rt;

  sc_regfile #(.W(XLEN), .NR(NREG)) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (rs),
    .ra2_i  (rt),
    .we_i   (ctrl.reg_write),
    .wa_i   (dst),
    .wd_i   (wb_data),
    .rd1_o  (rs_data),
    .rd2_o  (rt_data)
  );

  assign alu_b = ctrl.alu_src ? imm_sx : rt_data;

  sc_alu #(.W(XLEN)) i_alu (
    .a_i    (rs_data),
    .b_i    (alu_b),
    .fn_i   (alu_fn),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // data store: loads read combinationally, stores commit at the edge
  assign dm_idx   = alu_y[DAW+1:2];
  assign dm_rdata = dmem[dm_idx];
  assign dm_we    = ctrl.mem_write && rst_ni;

  always_ff @(posedge clk_i) begin
    if (load_we_i && load_dmem_i) dmem[load_addr_i[DAW-1:0]] <= load_data_i;
    else if (dm_we)               dmem[dm_idx] <= rt_data;
  end

  assign wb_data = ctrl.mem_read ? dm_rdata : alu_y;

  // next PC
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign taken     = ctrl.branch && alu_zero;
  assign pc_d      = taken ? br_target : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = ctrl.reg_write;
  assign rf_waddr_o = dst;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = dm_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_data;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IAW+2], load_addr_i,
                         instr[10:6]};

  // checks
  p_seq_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken |=> pc_q == $past(pc_q) + XLEN'(4));

  p_taken_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken |=> pc_q == $past(br_target));

  p_unknown_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_known |-> !ctrl.reg_write && !ctrl.mem_write && !ctrl.branch);

  p_load_wb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mem_read && ctrl.reg_write) |-> wb_data == dm_rdata);

  p_store_noreg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.mem_write |-> !ctrl.reg_write);

  p_r0_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs == '0) |-> rs_data == '0);

  p_addi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode == OPC_ADDI) |-> (dst == rt && wb_data == rs_data + imm_sx));

endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  import sc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0, ld_dm = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc, rf_wd, dm_addr, dm_wd;
  logic        rf_we, dm_we;
  logic [4:0]  rf_wa;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_core i_sc_core (
    .clk_i (clk), .rst_ni (rst_n),
    .load_we_i (ld_we), .load_dmem_i (ld_dm), .load_addr_i (ld_addr),
    .load_data_i (ld_data),
    .pc_o (pc), .rf_we_o (rf_we), .rf_waddr_o (rf_wa), .rf_wdata_o (rf_wd),
    .dm_we_o (dm_we), .dm_addr_o (dm_addr), .dm_wdata_o (dm_wd)
  );

  function automatic logic [31:0] enc_r(logic [5:0] op, logic [4:0] s, logic [4:0] t,
                                        logic [4:0] d, logic [5:0] fn);
    return {op, s, t, d, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] s, logic [4:0] t,
                                        logic [15:0] imm);
    return {op, s, t, imm};
  endfunction

  localparam int NPROG = 21;
  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(OPC_ADDI, 0, 1, 16'd8),            //  0
    enc_i(OPC_ADDI, 0, 2, 16'hFFFD),         //  4
    enc_r(OPC_RTYPE, 1, 2, 3, FN_ADD),       //  8
    enc_r(OPC_RTYPE, 2, 1, 4, FN_SUB),       // 12
    enc_r(OPC_RTYPE, 1, 3, 5, FN_AND),       // 16
    enc_r(OPC_RTYPE, 1, 3, 6, FN_OR),        // 20
    enc_r(OPC_RTYPE, 2, 1, 7, FN_SLT),       // 24
    enc_r(OPC_RTYPE, 1, 2, 8, FN_SLT),       // 28
    enc_i(OPC_LW, 1, 9, 16'd12),             // 32
    enc_r(OPC_LDX, 1, 1, 10, 6'd0),          // 36
    enc_i(OPC_SW, 1, 3, 16'd4),              // 40
    enc_i(OPC_LW, 0, 12, 16'd12),            // 44
    enc_i(OPC_ADDI, 0, 0, 16'd77),           // 48
    enc_r(OPC_RTYPE, 0, 0, 13, FN_ADD),      // 52
    enc_i(OPC_BEQ, 3, 12, 16'd2),            // 56
    enc_i(OPC_ADDI, 0, 14, 16'd1),           // 60 skipped
    enc_i(OPC_ADDI, 0, 14, 16'd2),           // 64 skipped
    enc_i(OPC_BEQ, 1, 2, 16'd5),             // 68
    enc_i(6'b111111, 1, 15, 16'h1234),       // 72
    enc_i(OPC_ADDI, 0, 15, 16'h7FFF),        // 76
    enc_i(OPC_BEQ, 0, 0, 16'hFFFF)           // 80
  };

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        mwe;
    logic [31:0] ma;
    logic [31:0] md;
  } step_t;

  localparam int NSTEP = 21;
  localparam step_t TRACE [NSTEP] = '{
    '{4'd3, 32'd0,  1'b1, 5'd1,  32'd8,        1'b0, 32'd0,  32'd0}, // R3
    '{4'd3, 32'd4,  1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 32'd0,  32'd0}, // R3 negative imm
    '{4'd2, 32'd8,  1'b1, 5'd3,  32'd5,        1'b0, 32'd0,  32'd0}, // R2 add
    '{4'd2, 32'd12, 1'b1, 5'd4,  32'hFFFFFFF5, 1'b0, 32'd0,  32'd0}, // R2 sub
    '{4'd2, 32'd16, 1'b1, 5'd5,  32'd0,        1'b0, 32'd0,  32'd0}, // R2 and
    '{4'd2, 32'd20, 1'b1, 5'd6,  32'd13,       1'b0, 32'd0,  32'd0}, // R2 or
    '{4'd2, 32'd24, 1'b1, 5'd7,  32'd1,        1'b0, 32'd0,  32'd0}, // R2 slt signed
    '{4'd2, 32'd28, 1'b1, 5'd8,  32'd0,        1'b0, 32'd0,  32'd0}, // R2 slt reversed
    '{4'd4, 32'd32, 1'b1, 5'd9,  32'd7,        1'b0, 32'd0,  32'd0}, // R4
    '{4'd7, 32'd36, 1'b1, 5'd10, 32'hDEADBEEF, 1'b0, 32'd0,  32'd0}, // R7
    '{4'd5, 32'd40, 1'b0, 5'd0,  32'd0,        1'b1, 32'd12, 32'd5}, // R5
    '{4'd5, 32'd44, 1'b1, 5'd12, 32'd5,        1'b0, 32'd0,  32'd0}, // R5 read back
    '{4'd8, 32'd48, 1'b1, 5'd0,  32'd77,       1'b0, 32'd0,  32'd0}, // R8 write to r0
    '{4'd8, 32'd52, 1'b1, 5'd13, 32'd0,        1'b0, 32'd0,  32'd0}, // R8 r0 still zero
    '{4'd6, 32'd56, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}, // R6 taken fwd
    '{4'd6, 32'd68, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}, // R6 not taken
    '{4'd9, 32'd72, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}, // R9
    '{4'd9, 32'd76, 1'b1, 5'd15, 32'h00007FFF, 1'b0, 32'd0,  32'd0}, // R9 pc+4
    '{4'd6, 32'd80, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}, // R6 taken back
    '{4'd6, 32'd80, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},
    '{4'd6, 32'd80, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}
  };

  task automatic chk(string what, int req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_word(logic dm, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_dm = dm; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset across edges
    chk("pc in reset", 1, pc, 32'd0);
    chk("store in reset", 1, {31'd0, dm_we}, 32'd0);
    for (int i = 0; i < NPROG; i++) load_word(1'b0, 8'(i), PROG[i]);
    load_word(1'b1, 8'd4, 32'hDEADBEEF);
    load_word(1'b1, 8'd5, 32'd7);
    chk("pc after load cycles", 1, pc, 32'd0);
    chk("store gated in reset", 1, {31'd0, dm_we}, 32'd0);

    rst_n = 1'b1;
    for (int i = 0; i < NSTEP; i++) begin
      #1;
      chk("pc", int'(TRACE[i].req), pc, TRACE[i].pc);
      chk("reg we", int'(TRACE[i].req), {31'd0, rf_we}, {31'd0, TRACE[i].we});
      if (TRACE[i].we) begin
        chk("reg addr", int'(TRACE[i].req), {27'd0, rf_wa}, {27'd0, TRACE[i].wa});
        chk("reg data", int'(TRACE[i].req), rf_wd, TRACE[i].wd);
      end
      chk("mem we", int'(TRACE[i].req), {31'd0, dm_we}, {31'd0, TRACE[i].mwe});
      if (TRACE[i].mwe) begin
        chk("mem addr", int'(TRACE[i].req), dm_addr, TRACE[i].ma);
        chk("mem data", int'(TRACE[i].req), dm_wd, TRACE[i].md);
      end
      @(negedge clk);
    end

    // R1: asynchronous reset mid-cycle clears the PC without an edge
    #2;
    rst_n = 1'b0;
    #1;
    chk("pc async clear", 1, pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("restart pc", 1, pc, 32'd0);
    chk("restart first write", 3, rf_wd, 32'd8);
    @(negedge clk);
    #1;
    chk("restart second pc", 6, pc, 32'd4);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule